// File: doc/BRIEF.md
# Software-Fed Raw Transmit Queue

This block is a small first-in first-out buffer that software loads one word at a time. Every write strobe from the register decoder offers one word of `(1+DDR)*LANES` bits. The word is stored unless the queue is already full and nothing leaves in that cycle, in which case the write is dropped without notice. A clear strobe empties the queue at once.

On the link side, a valid/ready handshake hands out the oldest word, together with a destination mask that has one bit per channel. Words are offered only while the transmit enable is high. An all-ones mask means the word goes to every channel, and the block flags that case on a separate broadcast output.

A 32-bit status word reports the number of stored entries in its low bits and the full condition in bit 31. The register decoder can return it to software as it is.

Top module: `rawtx_fifo`

## Requirements
- R1: After reset the queue is empty: the status word is zero and `out_valid_o` is low.
- R2: A write strobe while the queue is not full stores `wr_data_i` and raises the entry count by one.
- R3: A write strobe while the queue is full, with no word leaving in the same cycle, is ignored: the count stays the same and the stored words are not changed.
- R4: Words leave in the order they were written.
- R5: `out_valid_o` is high only when `tx_en_i` is high and the queue holds at least one word. While `tx_en_i` is low, no word leaves, whatever `out_ready_i` does.
- R6: A word leaves only in a cycle where `out_valid_o` and `out_ready_i` are both high, and the count then falls by one.
- R7: A write and a departure in the same cycle leave the count unchanged. They are accepted even when the queue is full.
- R8: `clr_i` empties the queue on the next edge, and it takes priority over a write in the same cycle.
- R9: Status layout: bits [CNT_W-1:0] hold the entry count (CNT_W = ADDR_W+1), bit 31 is 1 exactly when the count equals 2^ADDR_W, and all other bits are 0.
- R10: `out_mask_o` equals `ch_mask_i` while `out_valid_o` is high and is zero otherwise. `out_bcast_o` is high exactly when `out_valid_o` is high and every bit of `ch_mask_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_stb_i | input | 1 | Software write event on the data register |
| wr_data_i | input | WORD_W | Word to store |
| clr_i | input | 1 | Empty the queue |
| tx_en_i | input | 1 | Allow words to leave |
| ch_mask_i | input | NUM_CH | Destination channel mask |
| out_valid_o | output | 1 | A word is offered |
| out_ready_i | input | 1 | Link side takes the word |
| out_data_o | output | WORD_W | Oldest stored word |
| out_mask_o | output | NUM_CH | Destination mask sent with the word |
| out_bcast_o | output | 1 | Offered word goes to all channels |
| status_o | output | 32 | Entry count and full flag |

## Verification
`out_valid_o`, `out_data_o`, `out_mask_o` and `out_bcast_o` follow from the stored state and the present inputs, so they are due in the same cycle that the inputs are applied. `status_o` reflects a write, departure or clear only after the clock edge that accepts it. The bench drives each cycle's inputs on the falling edge and samples every output shortly afterwards. At that point the handshake outputs show the current cycle and the status word shows the result of the previous edge. The bench's queue model is advanced only after these checks, so the two kinds of result are never compared against the wrong cycle.

// File: rtl/rawtx_pkg.sv
package rawtx_pkg;

    localparam int unsigned STATUS_W = 32;
    localparam int unsigned FULL_POS = 31;
    localparam int unsigned CNT_MAX_W = 16;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } queue_op_e;

    function automatic queue_op_e classify(input logic push, input logic pop);
        return queue_op_e'({pop, push});
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(
        input logic [CNT_MAX_W-1:0] cnt,
        input logic                 full
    );
        logic [STATUS_W-1:0] w;
        w                       = '0;
        w[CNT_MAX_W-1:0]        = cnt;
        w[FULL_POS]             = full;
        return w;
    endfunction

endpackage

// File: rtl/rawtx_store.sv
module rawtx_store #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (we_i && (waddr_i == ADDR_W'(i))) begin
                mem_q[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/rawtx_ctrl.sv
module rawtx_ctrl
    import rawtx_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_stb_i,
    input  logic              clr_i,
    input  logic              pop_i,
    output logic              push_o,
    output logic [ADDR_W-1:0] wr_ptr_o,
    output logic [ADDR_W-1:0] rd_ptr_o,
    output logic [ADDR_W:0]   count_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int unsigned CNT_W = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    queue_op_e         op;

    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);
    // a departure in the same cycle frees a slot for the incoming word
    assign push_o  = wr_stb_i && (!full_o || pop_i) && !clr_i;
    assign op      = classify(push_o, pop_i && !clr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
                    count_q  <= count_q + CNT_W'(1);
                end
                OP_POP: begin
                    rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
                    count_q  <= count_q - CNT_W'(1);
                end
                OP_BOTH: begin
                    wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
                    rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign wr_ptr_o = wr_ptr_q;
    assign rd_ptr_o = rd_ptr_q;
    assign count_o  = count_q;

endmodule

// File: rtl/rawtx_egress.sv
module rawtx_egress #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              tx_en_i,
    input  logic              empty_i,
    input  logic              ready_i,
    input  logic [NUM_CH-1:0] mask_i,
    output logic              valid_o,
    output logic              pop_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic              bcast_o
);
    assign valid_o = tx_en_i && !empty_i;
    assign pop_o   = valid_o && ready_i;
    assign mask_o  = valid_o ? mask_i : '0;
    assign bcast_o = valid_o && (&mask_i);

endmodule

// File: rtl/rawtx_fifo.sv
module rawtx_fifo
    import rawtx_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned LANES  = 8,
    parameter int unsigned DDR    = 1,
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned WORD_W = (1 + DDR) * LANES
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_stb_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    input  logic                clr_i,
    input  logic                tx_en_i,
    input  logic [NUM_CH-1:0]   ch_mask_i,
    output logic                out_valid_o,
    input  logic                out_ready_i,
    output logic [WORD_W-1:0]   out_data_o,
    output logic [NUM_CH-1:0]   out_mask_o,
    output logic                out_bcast_o,
    output logic [STATUS_W-1:0] status_o
);
    localparam int unsigned CNT_W = ADDR_W + 1;

    logic              push, pop, full, empty;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    rawtx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_stb_i (wr_stb_i),
        .clr_i    (clr_i),
        .pop_i    (pop),
        .push_o   (push),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .count_o  (count),
        .full_o   (full),
        .empty_o  (empty)
    );

    rawtx_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk_i   (clk_i),
        .we_i    (push),
        .waddr_i (wr_ptr),
        .wdata_i (wr_data_i),
        .raddr_i (rd_ptr),
        .rdata_o (out_data_o)
    );

    rawtx_egress #(.NUM_CH(NUM_CH)) u_egress (
        .tx_en_i (tx_en_i),
        .empty_i (empty),
        .ready_i (out_ready_i),
        .mask_i  (ch_mask_i),
        .valid_o (out_valid_o),
        .pop_o   (pop),
        .mask_o  (out_mask_o),
        .bcast_o (out_bcast_o)
    );

    assign status_o = pack_status(CNT_MAX_W'(count), full);

endmodule

// File: rtl/rawtx_fifo_chk.sv
module rawtx_fifo_chk #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_stb_i,
    input logic              clr_i,
    input logic              tx_en_i,
    input logic              out_ready_i,
    input logic              out_valid_o,
    input logic [NUM_CH-1:0] out_mask_o,
    input logic [31:0]       status_o
);
    localparam int unsigned CNT_W = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [CNT_W-1:0] cnt;
    logic             full, pop;
    assign cnt  = status_o[CNT_W-1:0];
    assign full = status_o[31];
    assign pop  = out_valid_o && out_ready_i;

    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt <= CNT_W'(DEPTH));
    p_drop_when_full_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        full && wr_stb_i && !pop && !clr_i |=> $stable(status_o));
    p_push_inc_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_stb_i && !full && !pop && !clr_i |=> cnt == $past(cnt) + CNT_W'(1));
    p_gate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !tx_en_i || cnt == '0 |-> !out_valid_o);
    p_pop_dec_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pop && !wr_stb_i && !clr_i |=> cnt == $past(cnt) - CNT_W'(1));
    p_both_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        pop && wr_stb_i && !clr_i |=> $stable(status_o));
    p_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> status_o == '0);
    p_mask_idle_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !out_valid_o |-> out_mask_o == '0);

endmodule

bind rawtx_fifo rawtx_fifo_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_stb_i    (wr_stb_i),
    .clr_i       (clr_i),
    .tx_en_i     (tx_en_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_mask_o  (out_mask_o),
    .status_o    (status_o)
);

// File: tb/rawtx_fifo_tb_top.sv
module rawtx_fifo_tb_top;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 8;
    localparam int WORD_W = 16;
    localparam int NUM_CH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_stb, clr, tx_en, ready;
    logic [WORD_W-1:0] wr_data;
    logic [NUM_CH-1:0] ch_mask;
    logic              valid, bcast;
    logic [WORD_W-1:0] data;
    logic [NUM_CH-1:0] mask;
    logic [31:0]       status;

    int total = 0;
    int bad   = 0;
    logic [WORD_W-1:0] model_q [$];

    always #10 clk = ~clk;

    rawtx_fifo #(.ADDR_W(ADDR_W), .LANES(8), .DDR(1), .NUM_CH(NUM_CH)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
        .clr_i(clr), .tx_en_i(tx_en), .ch_mask_i(ch_mask), .out_valid_o(valid),
        .out_ready_i(ready), .out_data_o(data), .out_mask_o(mask),
        .out_bcast_o(bcast), .status_o(status)
    );

    function automatic logic [31:0] exp_status(input int n);
        logic [31:0] w = 32'(n);
        w[31] = (n == DEPTH);
        return w;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit w, input logic [WORD_W-1:0] d, input bit c,
                        input bit en, input bit rdy, input logic [NUM_CH-1:0] m,
                        input string tag);
        bit ev, pp, ps, fl;
        @(negedge clk);
        wr_stb = w; wr_data = d; clr = c; tx_en = en; ready = rdy; ch_mask = m;
        #2;
        ev = en && (model_q.size() > 0);
        chk(tag, "status R9", status, exp_status(model_q.size()));
        chk(tag, "valid R5", 32'(valid), 32'(ev));
        if (ev) chk(tag, "data R4", 32'(data), 32'(model_q[0]));
        chk(tag, "mask R10", 32'(mask), ev ? 32'(m) : 32'd0);
        chk(tag, "bcast R10", 32'(bcast), 32'(ev && (&m)));
        pp = ev && rdy;
        fl = (model_q.size() == DEPTH);
        ps = w && (!fl || pp);
        if (c) model_q.delete();
        else begin
            if (pp) void'(model_q.pop_front());
            if (ps) model_q.push_back(d);
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; wr_stb = 0; wr_data = '0; clr = 0; tx_en = 0; ready = 0; ch_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", "status", status, 32'd0);
        chk("R1", "valid", 32'(valid), 32'd0);

        // R2: fill with enable low
        for (int i = 0; i < DEPTH; i++) step(1, 16'hA000 + 16'(i), 0, 0, 1, 4'h3, "R2");
        // R9 / R5: full, nothing leaves while disabled
        step(0, '0, 0, 0, 1, 4'h3, "R9");
        chk("R9", "full bit", 32'(status[31]), 32'd1);
        // R3: overflow write dropped
        step(1, 16'hDEAD, 0, 0, 1, 4'h3, "R3");
        step(0, '0, 0, 0, 0, 4'h3, "R3");
        // R7: write and departure together while full
        step(1, 16'hB007, 0, 1, 1, 4'hF, "R7");
        step(0, '0, 0, 1, 0, 4'hF, "R7");
        // R6: valid without ready keeps word
        step(0, '0, 0, 1, 0, 4'h5, "R6");
        // R4 / R10: drain with varied masks
        for (int i = 0; i < DEPTH; i++) step(0, '0, 0, 1, 1, 4'(i + 8), "R4");
        step(0, '0, 0, 1, 1, 4'hF, "R5");
        chk("R5", "empty status", status, 32'd0);
        // R8: clear beats write
        for (int i = 0; i < 3; i++) step(1, 16'hC000 + 16'(i), 0, 0, 0, '0, "R8");
        step(1, 16'hCAFE, 1, 1, 1, 4'hF, "R8");
        step(0, '0, 0, 1, 1, 4'hF, "R8");
        chk("R8", "cleared", status, 32'd0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 100) < 55, 16'($urandom), ($urandom % 100) < 3,
                 ($urandom % 100) < 70, ($urandom % 100) < 50,
                 (($urandom % 4) == 0) ? 4'hF : 4'($urandom), "R2 R4 R6 R7");
        end
        step(0, '0, 0, 0, 0, '0, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule